// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital control for a successive-approximation converter. It steps through a conversion in the cycles of an ADC clock enable that is derived from the system clock. It drives a trial code to the converter's DAC and reads back a single comparator bit. At the end of a conversion it publishes the result as a high byte and a low byte. The analog front end and the generation of the clock enable are outside the block.

The CPU writes channel and reference select bits into a holding register. The converter never sees that holding register directly. It sees an active copy instead. While the converter is idle, the active copy takes the held value on every ADC clock. During a conversion the active copy is frozen. It is refreshed again on the final ADC clock of the conversion, which is the same clock that raises the done flag.

A conversion is requested with a start strobe. It is run either once or repeatedly in free-running mode. The first conversion after the converter is enabled uses a longer sequence, so that the analog parts can settle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, done, irq, both result bytes and the active selection all read 0.
- R2: While no conversion runs, sel_active takes the value held from sel_wdata at every adc_tick edge, and at no other edge. The tick edge on which the holding register is written still passes the previous held value.
- R3: From the first cycle of a conversion until its final cycle, sel_active ignores any new sel_wdata writes.
- R4: On the final ADC cycle of a conversion, sel_active loads the current held value, at the same edge that sets done.
- R5: A conversion starts on the first adc_tick edge strictly after the edge that registers start_wr, never on that edge itself.
- R6: A normal conversion lasts 13 ADC cycles, counting the start cycle as cycle 1. Done rises at the 13th tick edge.
- R7: The first conversion after adc_en rises (or after reset) lasts 25 ADC cycles. Every later conversion is normal.
- R8: hold_strobe is high for the single system clock before the tick edge of ADC cycle 2 in a normal conversion, or of ADC cycle 14 in an extended one.
- R9: Bits are decided MSB first, one per ADC cycle. cmp_in=1 means the input is at or above dac_code and keeps the trial bit. At completion, res_hi[1:0] gets result bits 9:8 with zeros above, and res_lo gets bits 7:0. Both bytes change only at completion.
- R10: With free_run=1, each completion is followed by a new start on the next tick without a new start_wr, and busy stays 1.
- R11: busy reads 1 from the edge after start_wr until completion. It clears at completion in single mode. start_wr is ignored while busy.
- R12: done stays set until a done_clr pulse. If a completion and done_clr fall in the same cycle, done stays set. irq equals done AND irq_en.
- R13: Deasserting adc_en aborts any conversion, so that busy is 0 on the next cycle and no done follows. start_wr is ignored while adc_en is 0, and the next conversion after re-enable is extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_tick | input | 1 | ADC clock enable, one system cycle wide |
| adc_en | input | 1 | Converter enable; low aborts and re-arms the long sequence |
| free_run | input | 1 | 1 = restart after every completion |
| irq_en | input | 1 | Interrupt enable |
| start_wr | input | 1 | Start strobe |
| done_clr | input | 1 | Clear strobe for the done flag |
| sel_wr | input | 1 | Write strobe for the select holding register |
| sel_wdata | input | SEL_W (5) | Channel and reference select value |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above dac_code |
| dac_code | output | RES_W (10) | Trial code to the DAC |
| hold_strobe | output | 1 | Sample-and-hold instant |
| sel_active | output | SEL_W (5) | Selection in use by the converter |
| busy | output | 1 | Start bit readback |
| done | output | 1 | Conversion complete flag |
| irq | output | 1 | Interrupt request |
| res_hi | output | 8 | Result bits above bit 7, zero-extended |
| res_lo | output | 8 | Result bits 7:0 |

## Verification
Completion sets done and refreshes the selection on the same tick edge, while software may be clearing done on that exact edge. The bench tracks the tick count since the start write. It raises done_clr in the one system cycle whose following edge is the 13th tick of a normal conversion, with done already set from the previous conversion. It then expects done to stay set and the new result to be visible. A selection written midway through a conversion is judged at the same completion edge: sel_active must show the new value exactly when done rises, and must not show it before.

// File: rtl/adc_seq_pkg.sv
// Package: shared types of the ADC conversion sequencer.
// Assumes: nothing beyond a single clock domain.
package adc_seq_pkg;

    // Per-tick events decoded by the timer and consumed by the SAR and top.
    typedef struct packed {
        logic begin_c;  // ADC cycle 1 of a conversion
        logic hold;     // sample-and-hold cycle
        logic step;     // one result bit is decided
        logic cmpl;     // final cycle of the conversion
    } seq_evt_t;

endpackage

// File: rtl/adc_seq_timer.sv
// Module: adc_seq_timer
// Counts ADC cycles of a conversion, keeps the start request, and arms
// the extended first-conversion sequence. Decodes per-tick events.
// Assumes: adc_tick is a one-cycle enable; start_wr is a one-cycle strobe.
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int NORM_SH = 2,
    parameter int EXT_SH  = 14,
    localparam int PW     = $clog2(RES_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adc_tick,
    input  logic          adc_en,
    input  logic          start_wr,
    input  logic          free_run,
    output seq_evt_t      evt,
    output logic [PW-1:0] step_pos,
    output logic          running,
    output logic          busy
);
    localparam int N_NORM = NORM_SH + RES_W + 1;
    localparam int N_EXT  = EXT_SH + RES_W + 1;
    localparam int CW     = $clog2(N_EXT + 1);

    logic [CW-1:0] cnt;
    logic          pending;
    logic          first_arm;
    logic          ext_cur;
    logic [CW-1:0] last_c;
    logic [CW-1:0] sh_c;

    // Purpose: pick the cycle limits of the running sequence.
    always_comb begin
        last_c = ext_cur ? CW'(N_EXT - 1) : CW'(N_NORM - 1);
        sh_c   = ext_cur ? CW'(EXT_SH)    : CW'(NORM_SH);
    end

    // Purpose: decode status and the events of the coming tick edge.
    always_comb begin
        running     = (cnt != '0);
        busy        = pending | running;
        evt.begin_c = adc_tick & adc_en & ~running & pending;
        evt.cmpl    = adc_tick & adc_en & running & (cnt == last_c);
        evt.hold    = adc_tick & adc_en & running & (cnt == sh_c - CW'(1));
        evt.step    = adc_tick & adc_en & running & (cnt >= sh_c)
                      & (cnt < sh_c + CW'(RES_W));
        step_pos    = PW'(RES_W - 1) - PW'(cnt - sh_c);
    end

    // Purpose: advance the cycle count and manage request and arming bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            pending   <= 1'b0;
            first_arm <= 1'b1;
            ext_cur   <= 1'b0;
        end else if (!adc_en) begin
            cnt       <= '0;
            pending   <= 1'b0;
            first_arm <= 1'b1;
        end else begin
            if (start_wr && !busy) begin
                pending <= 1'b1;
            end
            if (evt.begin_c) begin
                cnt       <= CW'(1);
                ext_cur   <= first_arm;
                first_arm <= 1'b0;
                pending   <= free_run;
            end else if (evt.cmpl) begin
                cnt <= '0;
                if (!free_run) begin
                    pending <= 1'b0;
                end
            end else if (adc_tick && running) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/adc_sel_shadow.sv
// Module: adc_sel_shadow
// Holding register for the CPU select value plus the active copy used by
// the converter. The active copy follows on ticks unless locked.
// Assumes: lock is high for the whole conversion, unlock_now on its last tick.
module adc_sel_shadow #(
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_tick,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             lock,
    input  logic             unlock_now,
    output logic [SEL_W-1:0] sel_active
);
    logic [SEL_W-1:0] sel_hold;

    // Purpose: capture CPU writes into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_hold <= '0;
        end else if (sel_wr) begin
            sel_hold <= sel_wdata;
        end
    end

    // Purpose: refresh the active copy at safe tick edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_active <= '0;
        end else if (adc_tick && (!lock || unlock_now)) begin
            sel_active <= sel_hold;
        end
    end

endmodule

// File: rtl/adc_sar_reg.sv
// Module: adc_sar_reg
// Successive-approximation register: seeds the MSB at the hold event, then
// resolves one bit per step, MSB first, from the comparator.
// Assumes: cmp_in is 1 when the input is at or above dac_code.
module adc_sar_reg #(
    parameter int RES_W   = 10,
    localparam int PW     = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             step,
    input  logic [PW-1:0]    step_pos,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code
);
    logic [RES_W-1:0] trial_nxt;

    // Purpose: decide the current bit and set the next trial bit.
    always_comb begin
        trial_nxt           = dac_code;
        trial_nxt[step_pos] = cmp_in;
        if (step_pos != '0) begin
            trial_nxt[step_pos - PW'(1)] = 1'b1;
        end
    end

    // Purpose: hold the trial code driven to the DAC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= '0;
        end else if (hold) begin
            dac_code <= RES_W'(1) << (RES_W - 1);
        end else if (step) begin
            dac_code <= trial_nxt;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: adc_seq_ctrl (top)
// Conversion sequencer for a successive-approximation ADC: timing, select
// shadowing, SAR, done flag, interrupt and result bytes.
// Assumes: RES_W between 9 and 16; adc_tick one system cycle wide.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int SEL_W   = 5,
    parameter int NORM_SH = 2,
    parameter int EXT_SH  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_tick,
    input  logic             adc_en,
    input  logic             free_run,
    input  logic             irq_en,
    input  logic             start_wr,
    input  logic             done_clr,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             hold_strobe,
    output logic [SEL_W-1:0] sel_active,
    output logic             busy,
    output logic             done,
    output logic             irq,
    output logic [7:0]       res_hi,
    output logic [7:0]       res_lo
);
    localparam int PW = $clog2(RES_W);

    seq_evt_t      evt;
    logic [PW-1:0] step_pos;
    logic          running;

    adc_seq_timer #(
        .RES_W   (RES_W),
        .NORM_SH (NORM_SH),
        .EXT_SH  (EXT_SH)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .adc_tick (adc_tick),
        .adc_en   (adc_en),
        .start_wr (start_wr),
        .free_run (free_run),
        .evt      (evt),
        .step_pos (step_pos),
        .running  (running),
        .busy     (busy)
    );

    adc_sel_shadow #(
        .SEL_W (SEL_W)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .adc_tick   (adc_tick),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .lock       (running),
        .unlock_now (evt.cmpl),
        .sel_active (sel_active)
    );

    adc_sar_reg #(
        .RES_W (RES_W)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (evt.hold),
        .step     (evt.step),
        .step_pos (step_pos),
        .cmp_in   (cmp_in),
        .dac_code (dac_code)
    );

    // Purpose: expose the sample instant to the analog front end.
    always_comb hold_strobe = evt.hold;

    // Purpose: sticky done flag; a completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (evt.cmpl) begin
            done <= 1'b1;
        end else if (done_clr) begin
            done <= 1'b0;
        end
    end

    // Purpose: load both result bytes together at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
        end else if (evt.cmpl) begin
            res_hi <= 8'(dac_code >> 8);
            res_lo <= dac_code[7:0];
        end
    end

    // Purpose: gate the interrupt request by its enable.
    always_comb irq = done & irq_en;

endmodule

// File: rtl/adc_seq_checker.sv
// Module: adc_seq_checker
// Temporal checks on the sequencer, attached to the top through bind.
// Assumes: clocked by the sequencer clock, reset synchronous active-low.
module adc_seq_checker #(
    parameter int SEL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_en,
    input logic             free_run,
    input logic             done_clr,
    input logic             busy,
    input logic             done,
    input logic             hold_strobe,
    input logic             conv_lock,
    input logic             conv_cmpl,
    input logic [SEL_W-1:0] sel_active,
    input logic [7:0]       res_hi,
    input logic [7:0]       res_lo
);
    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_lock && !conv_cmpl) |=> $stable(sel_active)); // R3

    AST_DONE_FROM_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(conv_cmpl)); // R4

    AST_HOLD_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        hold_strobe |=> busy); // R8

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_cmpl |=> ($stable(res_hi) && $stable(res_lo))); // R9

    AST_FREE_RUN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_cmpl && free_run && adc_en) |=> busy); // R10

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done); // R12

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_en |=> !busy); // R13

endmodule

bind adc_seq_ctrl adc_seq_checker #(.SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_en      (adc_en),
    .free_run    (free_run),
    .done_clr    (done_clr),
    .busy        (busy),
    .done        (done),
    .hold_strobe (hold_strobe),
    .conv_lock   (running),
    .conv_cmpl   (evt.cmpl),
    .sel_active  (sel_active),
    .res_hi      (res_hi),
    .res_lo      (res_lo)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div = 2'd0;
    logic       adc_tick;
    logic       adc_en = 1'b0, free_run = 1'b0, irq_en = 1'b0;
    logic       start_wr = 1'b0, done_clr = 1'b0, sel_wr = 1'b0;
    logic [4:0] sel_wdata = '0;
    logic [9:0] vin = '0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       hold_strobe, busy, done, irq;
    logic [4:0] sel_active;
    logic [7:0] res_hi, res_lo;

    int total = 0, bad = 0, tcount = 0, ref_t = 0, hold_seen = 0;
    bit mon_en = 0;
    logic done_q = 1'b0;

    typedef struct {
        int lat; int sh; int hi; int lo; int sel; string tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;
    assign adc_tick = (div == 2'd3);
    assign cmp_in   = (vin >= dac_code);
    always @(posedge clk) begin
        div <= rst_n ? div + 2'd1 : 2'd0;
        if (adc_tick) tcount <= tcount + 1;
    end

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .adc_en(adc_en),
        .free_run(free_run), .irq_en(irq_en), .start_wr(start_wr),
        .done_clr(done_clr), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .cmp_in(cmp_in), .dac_code(dac_code), .hold_strobe(hold_strobe),
        .sel_active(sel_active), .busy(busy), .done(done), .irq(irq),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wait_tick();
        @(negedge clk);
        while (!adc_tick) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write_sel(input logic [4:0] v);
        sel_wdata = v; sel_wr = 1'b1;
        @(negedge clk) sel_wr = 1'b0;
    endtask

    // Driver side: start strobe, reference tick recorded after the write edge.
    task automatic start_conv();
        @(negedge clk) start_wr = 1'b1;
        @(negedge clk) start_wr = 1'b0;
        ref_t = tcount;
        hold_seen = 0;
        chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    endtask

    task automatic push(input int lat, input int sh, input int v,
                        input int sel, input string tag);
        exp_t e;
        e.lat = lat; e.sh = sh; e.hi = v >> 8; e.lo = v & 255;
        e.sel = sel; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compares each completion against the next expected item.
    initial forever begin
        @(negedge clk);
        if (mon_en) begin
            if (hold_strobe) hold_seen = tcount - ref_t + 1;
            if (done && !done_q) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected completion", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(tcount - ref_t == e.lat, e.tag, "latency (R5 start)",
                        tcount - ref_t, e.lat);
                    chk(hold_seen == e.sh, "R8", "hold cycle", hold_seen, e.sh);
                    chk(res_hi == e.hi, "R9", "res_hi", res_hi, e.hi);
                    chk(res_lo == e.lo, "R9", "res_lo", res_lo, e.lo);
                    chk(sel_active == e.sel, "R4", "sel at completion",
                        sel_active, e.sel);
                    chk(irq == irq_en, "R12", "irq", irq, irq_en);
                end
                ref_t = tcount;
                hold_seen = 0;
                done_clr = 1'b1;
                @(negedge clk) done_clr = 1'b0;
            end
        end
        done_q = done;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(irq == 0, "R1", "irq", irq, 0);
        chk(res_hi == 0 && res_lo == 0, "R1", "result", {res_hi, res_lo}, 0);
        chk(sel_active == 0, "R1", "sel_active", sel_active, 0);

        // R2: follow only on tick edges, one tick behind the write
        write_sel(5'd5);
        chk(sel_active == 0, "R2", "sel before tick", sel_active, 0);
        wait_tick();
        chk(sel_active == 5, "R2", "sel after tick", sel_active, 5);

        adc_en = 1'b1; irq_en = 1'b1; mon_en = 1;
        // R7 first conversion is extended
        vin = 10'h2A5; push(25, 14, 'h2A5, 5, "R7");
        start_conv(); drain();
        chk(busy == 0, "R11", "busy cleared in single mode", busy, 0);

        // R6 normal conversions, extreme codes
        vin = 10'h3FF; push(13, 2, 'h3FF, 5, "R6"); start_conv(); drain();
        vin = 10'h000; push(13, 2, 0, 5, "R6"); start_conv(); drain();

        // R3 selection write during a conversion stays hidden until the end
        vin = 10'h155; push(13, 2, 'h155, 'h1B, "R6");
        start_conv();
        repeat (3) wait_tick();
        write_sel(5'h1B);
        repeat (2) wait_tick();
        chk(sel_active == 5, "R3", "sel locked", sel_active, 5);
        drain();

        // R10 free-running back-to-back conversions
        free_run = 1'b1; vin = 10'h0F0;
        repeat (3) push(13, 2, 'h0F0, 'h1B, "R10");
        start_conv(); drain();
        chk(busy == 1, "R10", "start bit held", busy, 1);
        mon_en = 0;
        adc_en = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R13", "abort clears busy", busy, 0);
        free_run = 1'b0;
        repeat (2) @(negedge clk);

        // R13 abort mid-conversion, start ignored while disabled
        adc_en = 1'b1;
        start_conv();
        repeat (5) wait_tick();
        adc_en = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R13", "busy after abort", busy, 0);
        repeat (30) wait_tick();
        chk(done == 0, "R13", "no completion after abort", done, 0);
        start_wr = 1'b1; @(negedge clk) start_wr = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R13", "start ignored when disabled", busy, 0);
        adc_en = 1'b1; mon_en = 1;
        vin = 10'h1C3; push(25, 14, 'h1C3, 'h1B, "R7");
        start_conv(); drain();

        // R12 sticky flag and completion colliding with a clear
        mon_en = 0;
        repeat (2) @(negedge clk);
        vin = 10'h0AA;
        start_conv();
        while (!done) @(negedge clk);
        chk(res_lo == 8'hAA, "R9", "res_lo", res_lo, 'hAA);
        repeat (6) @(negedge clk);
        chk(done == 1, "R12", "done sticky", done, 1);
        chk(irq == 1, "R12", "irq while done", irq, 1);
        vin = 10'h301;
        start_conv();
        while (!(tcount == ref_t + 12 && adc_tick)) @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        chk(done == 1, "R12", "set wins over clear", done, 1);
        chk(res_hi == 3 && res_lo == 1, "R9", "result at collision",
            {res_hi, res_lo}, 'h301);
        done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        chk(done == 0, "R12", "clear", done, 0);
        chk(irq == 0, "R12", "irq after clear", irq, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule